// File: doc/BRIEF.md
# Maskable Exception Latch and Interrupt Gate

This block gathers the floating-point exception events that a sequencer raises while one instruction runs, and decides whether an interrupt request goes out to the host. Six exception types are tracked. Each has a transient latch that lives for one instruction, a mask bit in a control field, and a sticky flag in a status field. A set pulse on a type sets its latch, and the latch holds until the next instruction starts. When the routine ends, the latched events are merged into the status flags. The flags keep their value until software clears them.

An exception is "new and unmasked" when its latch is set, its mask bit is clear and its status flag is still clear. While any type is in that state, a pending signal is high, so the sequencer can test it and cut the routine short. The same condition raises the interrupt request. The request then stays up until the software clear. A type that is already flagged, or that is masked, never raises the request.

The six types sit at fixed bit positions in the mask, status and event vectors: bit 0 invalid operation, bit 1 denormal operand, bit 2 zero divide, bit 3 overflow, bit 4 underflow, bit 5 precision.

Top module: `fxg_exc_unit`

## Requirements
- R1: After synchronous reset, `status_flags` is 0, `unmasked_pend` is 0 and `irq_req` is 0. All six mask bits reset to 1, so an event raised straight after reset produces no pending signal.
- R2: A one-cycle pulse on `exc_set[i]` sets latch i at that clock edge. The latch stays set until an `insn_start` edge, and is observed through `unmasked_pend` and through the copy into `status_flags`.
- R3: An `insn_start` edge clears all latches. An `exc_set` pulse in the same cycle as `insn_start` still sets its latch for the new instruction.
- R4: A `mask_we` edge loads all six mask bits from `mask_wdata`, using the bit order stated above. A mask bit of 1 keeps its type from making `unmasked_pend` or `irq_req` high.
- R5: From the edge after the state changes, `unmasked_pend` is 1 exactly when some type has its latch set, its mask bit 0 and its status flag 0. This includes the case where a mask write unmasks an already latched type.
- R6: A `routine_end` edge ORs all latches into `status_flags`. With no `routine_end` and no `sw_clr`, the flags hold their value.
- R7: A `sw_clr` edge sets `status_flags` to 0 and `irq_req` to 0. It takes priority over a `routine_end` in the same cycle.
- R8: `irq_req` goes high at the same edge as `unmasked_pend` goes high. It stays high until a `sw_clr`, even after the pending condition goes away.
- R9: Setting the latch of a type whose status flag is already 1 raises neither `unmasked_pend` nor `irq_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exc_set | input | 6 | One-cycle set pulse per exception type |
| insn_start | input | 1 | Pulse marking the start of a new instruction |
| routine_end | input | 1 | Pulse marking the end of the current routine |
| mask_we | input | 1 | Write enable for the mask field |
| mask_wdata | input | 6 | New mask bits (1 = masked) |
| sw_clr | input | 1 | Software clear of the status flags and the interrupt |
| status_flags | output | 6 | Sticky exception flags |
| unmasked_pend | output | 1 | A new unmasked exception is latched |
| irq_req | output | 1 | Interrupt request to the host |

## Verification
The bench targets the edges where two controls meet:
- A set pulse in the same cycle as an instruction start. A design that let the start win would drop the new event.
- A software clear in the same cycle as a routine end. A design that gave the copy priority would leave stale flags and hold the request high.
- An event on a type that is already flagged. A design that ignored the status term would raise repeat interrupts.
- A mask write that unmasks a type that is already latched. This must raise the pending signal at once.
- A request that must survive the routine-end copy. A design that tied the request to the pending signal would drop it early.

A randomized phase compares every output each cycle with a behavioural model, to catch order errors that the directed cases miss.

// File: rtl/fxg_pkg.sv
package fxg_pkg;
  localparam int EXC_COUNT = 6;

  typedef enum int {
    EXC_INVALID  = 0,
    EXC_DENORMAL = 1,
    EXC_ZERODIV  = 2,
    EXC_OVERFLOW = 3,
    EXC_UNDERFLOW= 4,
    EXC_PRECISION= 5
  } exc_idx_e;

  typedef logic [EXC_COUNT-1:0] exc_vec_t;
endpackage

// File: rtl/fxg_latch_bank.sv
module fxg_latch_bank #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic         start_i,
  output logic [N-1:0] latch_d,
  output logic [N-1:0] latch_q
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_bit
      assign latch_d[g] = (start_i ? 1'b0 : latch_q[g]) | set_i[g];

      always_ff @(posedge clk) begin
        if (rst) latch_q[g] <= 1'b0;
        else     latch_q[g] <= latch_d[g];
      end

      // R2: latch holds while no instruction start arrives
      a_r2_latch_hold: assert property (@(posedge clk) disable iff (rst)
        (latch_q[g] && !start_i) |=> latch_q[g]);
      // R3: start without a new set clears the latch
      a_r3_start_clear: assert property (@(posedge clk) disable iff (rst)
        (start_i && !set_i[g]) |=> !latch_q[g]);
      // R3: a set pulse always lands, even together with start
      a_r3_set_lands: assert property (@(posedge clk) disable iff (rst)
        set_i[g] |=> latch_q[g]);
    end
  endgenerate
endmodule

// File: rtl/fxg_mask_reg.sv
module fxg_mask_reg #(
  parameter int         N        = 6,
  parameter logic [N-1:0] RST_MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_i,
  input  logic [N-1:0] wdata_i,
  output logic [N-1:0] mask_d,
  output logic [N-1:0] mask_q
);
  assign mask_d = we_i ? wdata_i : mask_q;

  always_ff @(posedge clk) begin
    if (rst) mask_q <= RST_MASK;
    else     mask_q <= mask_d;
  end

  // R4: without a write the mask keeps its value
  a_r4_mask_hold: assert property (@(posedge clk) disable iff (rst)
    !we_i |=> $stable(mask_q));
endmodule

// File: rtl/fxg_status_reg.sv
module fxg_status_reg #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] latch_q,
  input  logic         end_i,
  input  logic         clr_i,
  output logic [N-1:0] status_d,
  output logic [N-1:0] status_q
);
  always_comb begin
    status_d = status_q;
    if (clr_i)      status_d = '0;
    else if (end_i) status_d = status_q | latch_q;
  end

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= status_d;
  end

  // R6: flags never fall without a software clear
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ((status_q & $past(status_q)) == $past(status_q)));
  // R6: flags only rise at a routine end
  a_r6_rise_at_end: assert property (@(posedge clk) disable iff (rst)
    (!end_i) |=> ((status_q & ~$past(status_q)) == '0));
  // R7: software clear empties the flags
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (status_q == '0));
endmodule

// File: rtl/fxg_irq_gate.sv
module fxg_irq_gate #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] latch_d,
  input  logic [N-1:0] mask_d,
  input  logic [N-1:0] status_d,
  input  logic         clr_i,
  output logic         pend_q,
  output logic         irq_q
);
  logic [N-1:0] fresh;
  logic         pend_d;
  logic         irq_d;

  assign fresh  = latch_d & ~mask_d & ~status_d;
  assign pend_d = |fresh;
  assign irq_d  = clr_i ? 1'b0 : (irq_q | pend_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      irq_q  <= irq_d;
    end
  end

  // R8: the request only rises together with a pending exception
  a_r8_irq_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_q) |-> pend_q);
  // R8: the request holds until software clears it
  a_r8_irq_hold: assert property (@(posedge clk) disable iff (rst)
    (irq_q && !clr_i) |=> irq_q);
  // R7: software clear drops the request
  a_r7_irq_drop: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> !irq_q);
  // R8: outside a clear cycle, pending implies request
  a_r8_pend_irq: assert property (@(posedge clk) disable iff (rst)
    (pend_q && !$past(clr_i)) |-> irq_q);
endmodule

// File: rtl/fxg_exc_unit.sv
module fxg_exc_unit #(
  parameter int                  N_EXC    = fxg_pkg::EXC_COUNT,
  parameter logic [N_EXC-1:0]    RST_MASK = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_EXC-1:0] exc_set,
  input  logic             insn_start,
  input  logic             routine_end,
  input  logic             mask_we,
  input  logic [N_EXC-1:0] mask_wdata,
  input  logic             sw_clr,
  output logic [N_EXC-1:0] status_flags,
  output logic             unmasked_pend,
  output logic             irq_req
);
  logic [N_EXC-1:0] latch_d, latch_q;
  logic [N_EXC-1:0] mask_d, mask_q;
  logic [N_EXC-1:0] status_d, status_q;

  fxg_latch_bank #(.N(N_EXC)) u_latch (
    .clk(clk), .rst(rst), .set_i(exc_set), .start_i(insn_start),
    .latch_d(latch_d), .latch_q(latch_q)
  );

  fxg_mask_reg #(.N(N_EXC), .RST_MASK(RST_MASK)) u_mask (
    .clk(clk), .rst(rst), .we_i(mask_we), .wdata_i(mask_wdata),
    .mask_d(mask_d), .mask_q(mask_q)
  );

  fxg_status_reg #(.N(N_EXC)) u_status (
    .clk(clk), .rst(rst), .latch_q(latch_q), .end_i(routine_end),
    .clr_i(sw_clr), .status_d(status_d), .status_q(status_q)
  );

  fxg_irq_gate #(.N(N_EXC)) u_gate (
    .clk(clk), .rst(rst), .latch_d(latch_d), .mask_d(mask_d),
    .status_d(status_d), .clr_i(sw_clr), .pend_q(unmasked_pend),
    .irq_q(irq_req)
  );

  assign status_flags = status_q;

  // R5: pending matches the registered latch, mask and flag state
  a_r5_pend_state: assert property (@(posedge clk) disable iff (rst)
    unmasked_pend == (|(latch_q & ~mask_q & ~status_q)));
  // R9: a flagged or masked type alone never leaves pending high
  a_r9_flagged_quiet: assert property (@(posedge clk) disable iff (rst)
    ((latch_q & ~(mask_q | status_q)) == '0) |-> !unmasked_pend);
endmodule

// File: tb/fxg_exc_unit_test.sv
module fxg_exc_unit_test;
  localparam int N = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] exc_set = '0;
  logic         insn_start = 1'b0;
  logic         routine_end = 1'b0;
  logic         mask_we = 1'b0;
  logic [N-1:0] mask_wdata = '0;
  logic         sw_clr = 1'b0;
  logic [N-1:0] status_flags;
  logic         unmasked_pend;
  logic         irq_req;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fxg_exc_unit uut (
    .clk(clk), .rst(rst), .exc_set(exc_set), .insn_start(insn_start),
    .routine_end(routine_end), .mask_we(mask_we), .mask_wdata(mask_wdata),
    .sw_clr(sw_clr), .status_flags(status_flags),
    .unmasked_pend(unmasked_pend), .irq_req(irq_req)
  );

  // Behavioural reference, one step per clock
  logic [N-1:0] m_lat, m_msk, m_sts;
  logic         m_pnd, m_irq;
  always @(posedge clk) begin
    logic [N-1:0] nl, nm, ns;
    logic np;
    if (rst) begin
      m_lat <= '0; m_msk <= '1; m_sts <= '0; m_pnd <= 1'b0; m_irq <= 1'b0;
    end else begin
      nl = insn_start ? exc_set : (m_lat | exc_set);
      nm = mask_we ? mask_wdata : m_msk;
      if (sw_clr) ns = '0;
      else if (routine_end) ns = m_sts | m_lat;
      else ns = m_sts;
      np = 1'b0;
      for (int i = 0; i < N; i++) if (nl[i] && !nm[i] && !ns[i]) np = 1'b1;
      m_lat <= nl; m_msk <= nm; m_sts <= ns; m_pnd <= np;
      m_irq <= sw_clr ? 1'b0 : (m_irq | np);
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // every cycle: compare with the model at the falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("model status", 32'(status_flags), 32'(m_sts));
      chk("model pend", 32'(unmasked_pend), 32'(m_pnd));
      chk("model irq", 32'(irq_req), 32'(m_irq));
    end
  end

  task automatic idle();
    exc_set = '0; insn_start = 0; routine_end = 0; mask_we = 0; sw_clr = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); #1; idle();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    #1;
    chk("R1 status after reset", 32'(status_flags), 0);
    chk("R1 pend after reset", 32'(unmasked_pend), 0);
    chk("R1 irq after reset", 32'(irq_req), 0);

    // R1/R4: masks reset set, invalid (bit0) event gives no pending
    exc_set = 6'b000001; step();
    chk("R1 masked at reset", 32'(unmasked_pend), 0);
    routine_end = 1; step();
    chk("R6 copy to flags", 32'(status_flags), 32'h01);
    chk("R8 no irq when masked", 32'(irq_req), 0);
    step();
    chk("R6 flags hold", 32'(status_flags), 32'h01);
    sw_clr = 1; insn_start = 1; step();
    chk("R7 clear flags", 32'(status_flags), 0);

    // R4: unmask zero divide (bit2) only
    mask_we = 1; mask_wdata = 6'b111011; step();
    exc_set = 6'b001000; step();              // overflow bit3, masked
    chk("R4 masked overflow quiet", 32'(unmasked_pend), 0);
    exc_set = 6'b000100; step();
    chk("R5 zero divide pending", 32'(unmasked_pend), 1);
    chk("R8 irq with pending", 32'(irq_req), 1);
    step();
    chk("R2 latch holds", 32'(unmasked_pend), 1);
    routine_end = 1; step();
    chk("R6 flags merged", 32'(status_flags), 32'h0C);
    chk("R9 pend drops after flag", 32'(unmasked_pend), 0);
    chk("R8 irq survives copy", 32'(irq_req), 1);

    // R9: repeat event on flagged type
    insn_start = 1; step();
    exc_set = 6'b000100; step();
    chk("R9 flagged type no pend", 32'(unmasked_pend), 0);
    insn_start = 1; sw_clr = 1; step();
    chk("R7 irq dropped", 32'(irq_req), 0);
    chk("R7 flags zero", 32'(status_flags), 0);
    exc_set = 6'b000100; step();
    chk("R9 after clear type raises again", 32'(irq_req), 1);
    insn_start = 1; sw_clr = 1; step();

    // R3: set together with start survives; start alone clears
    insn_start = 1; exc_set = 6'b000100; step();
    chk("R3 set with start kept", 32'(unmasked_pend), 1);
    insn_start = 1; step();
    chk("R3 start clears latch", 32'(unmasked_pend), 0);
    chk("R8 irq held", 32'(irq_req), 1);
    sw_clr = 1; step();

    // R7 priority over routine_end
    mask_we = 1; mask_wdata = '0; step();
    exc_set = 6'b100000; step();
    chk("R5 precision pending", 32'(unmasked_pend), 1);
    routine_end = 1; sw_clr = 1; step();
    chk("R7 clear beats copy", 32'(status_flags), 0);
    chk("R7 irq low at clear", 32'(irq_req), 0);
    chk("R5 still pending", 32'(unmasked_pend), 1);
    step();
    chk("R8 re-raised next cycle", 32'(irq_req), 1);
    insn_start = 1; sw_clr = 1; step();

    // R5: unmasking an already latched type raises pending
    mask_we = 1; mask_wdata = '1; step();
    exc_set = 6'b010000; step();
    chk("R4 underflow masked", 32'(unmasked_pend), 0);
    mask_we = 1; mask_wdata = 6'b101111; step();
    chk("R5 unmask latched raises", 32'(unmasked_pend), 1);
    chk("R2 latch reached flags path", 32'(irq_req), 1);

    // randomized phase, model compared every cycle
    for (int k = 0; k < 3000; k++) begin
      exc_set     = ($urandom_range(0, 3) == 0) ? N'($urandom) : '0;
      insn_start  = ($urandom_range(0, 7) == 0);
      routine_end = ($urandom_range(0, 7) == 0);
      mask_we     = ($urandom_range(0, 15) == 0);
      mask_wdata  = N'($urandom);
      sw_clr      = ($urandom_range(0, 19) == 0);
      @(posedge clk); @(negedge clk); #1;
    end
    idle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule